// File: doc/BRIEF.md
# Per-CPU Interval Timer Ignore Counter

This block fans a single periodic interval-timer tick out to four processors. Each processor has a programmable count that is decremented on every tick. Timer interrupts for that processor are held back until the count wraps below zero. The wrap sets a sticky overflow flag, and from then on every tick raises that processor's interrupt. Software can therefore skip a chosen number of ticks, and afterwards it can read the still-decrementing count to see how many ticks went by unserviced.

A plain register port gives read and write access to each processor's value. A one-cycle set pulse per processor is sent to the neighbouring timer status logic, which stores the interrupt state. A presence vector freezes the counters of processors that are not fitted and blocks their pulses. The tick input is sampled on the block clock, and only its rising edge has any effect. The register port is a plain single-cycle control port and has no back-pressure: a write takes effect at the next clock edge, and read data is combinational from the address.

Top module: `interval_ignore_ctr`

## Requirements
- R1: After reset, every processor's 25-bit value is zero (count 0, overflow clear) and `timer_set` is all zero.
- R2: The four processors' registers sit at byte offsets 0x380 (CPU0), 0x3C0 (CPU1), 0x700 (CPU2) and 0x740 (CPU3). A read returns the overflow flag in bit 24 and the count in bits 23:0, with bits 31:25 reading as zero. A read of any other address returns zero, and a write to any other address changes no value.
- R3: A write loads `csr_wdata[23:0]` as the count and clears the overflow flag. Bits 31:24 of the write data are ignored.
- R4: Only a rising edge of `tick_in` counts as a tick. The update happens at the first clock edge that samples `tick_in` high after it was sampled low. Holding the input high, and the falling edge, have no effect.
- R5: On a tick, each present processor's 25-bit value becomes (value − 1) mod 2^25, with bit 24 then ORed with its old value.
- R6: Once the overflow flag is set, it stays set through any number of ticks until that processor's register is written.
- R7: In the clock cycle after a tick's update, `timer_set[i]` is high for exactly one cycle if processor i's updated overflow flag is set. It is low in every other cycle.
- R8: A processor whose `cpu_present` bit is low is not decremented and gets no pulse.
- R9: If a write to processor i lands in the same cycle as a tick, the write wins. Processor i takes the written value, skips that tick's decrement and gets no pulse, while the other processors still take the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | Interval timer tick level; its rising edge counts |
| cpu_present | input | 4 | One bit per processor; low freezes that processor |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 12 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Read data for `csr_addr` (combinational) |
| timer_set | output | 4 | One-cycle timer interrupt set pulse per processor |

## Verification
The assertions check several rules on every cycle:
- the overflow flag never clears without a write;
- a pulse only follows a detected edge and only with the flag set;
- an absent or unaddressed processor's value holds still;
- a write lands exactly the written count;
- read bits 31:25 stay zero.

Only the bench's scenarios can show the arithmetic of the wrap from count zero, the exact skip count before the first pulse, write-over-tick priority in a shared cycle, and that a held-high or falling tick does nothing. It shows these by comparing readback values and pulse vectors against its own model over directed and random sequences.

// File: rtl/iic_pkg.sv
package iic_pkg;
  localparam int N_CPU  = 4;
  localparam int CNT_W  = 24;
  localparam int VAL_W  = CNT_W + 1;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int STEP   = 'h40;

  typedef logic [VAL_W-1:0] ival_t;

  // Register offset of a processor: two pairs, each pair spaced by STEP.
  function automatic logic [ADDR_W-1:0] cpu_offset(input int idx);
    int base;
    base = (idx < 2) ? 'h380 : 'h700;
    return ADDR_W'(base + (idx % 2) * STEP);
  endfunction
endpackage

// File: rtl/iic_tick_edge.sv
module iic_tick_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_in;
  end

  assign rise = level_in & ~level_q;
endmodule

// File: rtl/iic_csr_decode.sv
module iic_csr_decode
  import iic_pkg::*;
(
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  ival_t             vals [N_CPU],
  output logic [N_CPU-1:0]  wr_sel,
  output logic [DATA_W-1:0] rdata
);
  logic [N_CPU-1:0] hit;

  for (genvar g = 0; g < N_CPU; g++) begin : g_hit
    assign hit[g]    = (addr == cpu_offset(g));
    assign wr_sel[g] = wr & hit[g];
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < N_CPU; k++)
      if (hit[k]) rdata = rdata | DATA_W'(vals[k]);
  end

  // R2: read data above the overflow flag is always zero
  always_comb a_r2_upper_zero: assert (rdata[DATA_W-1:VAL_W] == '0);
  // R2: at most one register selected per write
  always_comb a_r2_one_sel: assert ($onehot0(wr_sel));
endmodule

// File: rtl/iic_counter_slice.sv
module iic_counter_slice
  import iic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic             tick,
  input  logic             present,
  output ival_t            value,
  output logic             set_pulse
);
  ival_t dec;

  always_comb begin
    dec = value - 1'b1;
    dec[VAL_W-1] = dec[VAL_W-1] | value[VAL_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value     <= '0;
      set_pulse <= 1'b0;
    end else if (wr_sel) begin
      value     <= {1'b0, wr_cnt};
      set_pulse <= 1'b0;
    end else if (tick && present) begin
      value     <= dec;
      set_pulse <= dec[VAL_W-1];
    end else begin
      set_pulse <= 1'b0;
    end
  end

  a_r6_sticky_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (value[VAL_W-1] && !wr_sel) |=> value[VAL_W-1]);
  a_r7_pulse_needs_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |-> value[VAL_W-1]);
  a_r7_pulse_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |-> $past(tick));
  a_r8_absent_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!present && !wr_sel) |=> $stable(value));
  a_r3_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> (value == {1'b0, $past(wr_cnt)}));
  a_r9_write_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> !set_pulse);
endmodule

// File: rtl/interval_ignore_ctr.sv
module interval_ignore_ctr
  import iic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic [N_CPU-1:0]  cpu_present,
  input  logic              csr_wr,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  output logic [N_CPU-1:0]  timer_set
);
  logic             tick;
  logic [N_CPU-1:0] wr_sel;
  ival_t            vals [N_CPU];

  iic_tick_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_in (tick_in),
    .rise     (tick)
  );

  iic_csr_decode u_dec (
    .wr     (csr_wr),
    .addr   (csr_addr),
    .vals   (vals),
    .wr_sel (wr_sel),
    .rdata  (csr_rdata)
  );

  for (genvar g = 0; g < N_CPU; g++) begin : g_cpu
    iic_counter_slice u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_sel    (wr_sel[g]),
      .wr_cnt    (csr_wdata[CNT_W-1:0]),
      .tick      (tick),
      .present   (cpu_present[g]),
      .value     (vals[g]),
      .set_pulse (timer_set[g])
    );
  end

  // R4: a held-high tick level never produces a second round of pulses
  a_r4_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_set != '0) |=> (timer_set == '0));
endmodule

// File: tb/interval_ignore_ctr_bench.sv
`timescale 1ns/1ps
module interval_ignore_ctr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_in = 1'b0;
  logic [3:0]  cpu_present = 4'hF;
  logic        csr_wr = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic [3:0]  timer_set;

  int n_cmp = 0;
  int n_bad = 0;
  logic [24:0] mdl [4];

  always #4 clk = ~clk;

  interval_ignore_ctr u_interval_ignore_ctr (
    .clk, .rst_n, .tick_in, .cpu_present, .csr_wr, .csr_addr,
    .csr_wdata, .csr_rdata, .timer_set
  );

  function automatic logic [11:0] off(input int i);
    case (i)
      0: return 12'h380;
      1: return 12'h3C0;
      2: return 12'h700;
      default: return 12'h740;
    endcase
  endfunction

  function automatic logic [24:0] f_dec(input logic [24:0] v);
    logic [24:0] n;
    n = v - 25'd1;
    n[24] = n[24] | v[24];
    return n;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input int i, input string req);
    @(negedge clk);
    csr_addr = off(i);
    #1 chk(req, csr_rdata, {7'b0, mdl[i]});
  endtask

  task automatic rd_all(input string req);
    for (int i = 0; i < 4; i++) rd_chk(i, req);
  endtask

  task automatic wr(input int i, input logic [31:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = off(i); csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0;
    mdl[i] = {1'b0, d[23:0]};
  endtask

  // one tick edge; wc >= 0 adds a coincident write to that processor
  task automatic do_tick(input logic [3:0] pres, input int wc, input logic [31:0] d, input string req);
    logic [3:0] ep;
    @(negedge clk);
    cpu_present = pres; tick_in = 1'b1;
    if (wc >= 0) begin csr_wr = 1'b1; csr_addr = off(wc); csr_wdata = d; end
    ep = '0;
    for (int i = 0; i < 4; i++) begin
      if (wc == i) mdl[i] = {1'b0, d[23:0]};
      else if (pres[i]) begin mdl[i] = f_dec(mdl[i]); ep[i] = mdl[i][24]; end
    end
    @(negedge clk);
    csr_wr = 1'b0; tick_in = 1'b0;
    chk({req, " R7 pulse"}, {28'b0, timer_set}, {28'b0, ep});
    @(negedge clk);
    chk("R7 pulse width", {28'b0, timer_set}, 32'h0);
    cpu_present = 4'hF;
  endtask

  initial begin
    #(8ns * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1C0FFEE));
    for (int i = 0; i < 4; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 timer_set", {28'b0, timer_set}, 32'h0);
    rd_all("R1 reset value");

    // R3 upper write bits ignored, R2 readback layout
    wr(0, 32'hFF12_3456);
    wr(1, 32'h0000_0002);
    wr(2, 32'h8000_0000);
    wr(3, 32'h00FF_FFFF);
    rd_all("R3 write");

    // R2 unmapped read and write
    @(negedge clk); csr_addr = 12'h384; #1 chk("R2 unmapped read", csr_rdata, 32'h0);
    @(negedge clk); csr_wr = 1'b1; csr_addr = 12'h400; csr_wdata = 32'h55;
    @(negedge clk); csr_wr = 1'b0;
    rd_all("R2 unmapped write");

    // R5/R7: CPU1 at 2 skips two ticks, pulses on the third; CPU2 at 0 wraps at once
    do_tick(4'hF, -1, 0, "R5 tick1");
    rd_all("R5 after tick1");
    do_tick(4'hF, -1, 0, "R5 tick2");
    do_tick(4'hF, -1, 0, "R5 tick3");
    rd_all("R5 after tick3");
    // R6 sticky
    do_tick(4'hF, -1, 0, "R6 tick4");
    rd_chk(1, "R6 sticky");
    rd_chk(2, "R6 sticky");

    // R4 hold high: a single decrement only
    @(negedge clk); tick_in = 1'b1;
    for (int i = 0; i < 4; i++) mdl[i] = f_dec(mdl[i]);
    repeat (6) @(negedge clk);
    chk("R4 held high no pulse", {28'b0, timer_set}, 32'h0);
    tick_in = 1'b0;
    repeat (3) @(negedge clk);
    rd_all("R4 held high single tick");

    // R6 write clears flag
    wr(2, 32'h5);
    rd_chk(2, "R6 cleared by write");

    // R8 absent processors
    do_tick(4'b0101, -1, 0, "R8 absent");
    rd_all("R8 absent frozen");

    // R9 write and tick together
    wr(0, 32'h0);
    do_tick(4'hF, 0, 32'h0, "R9 coincident");
    rd_all("R9 write wins");

    // random mix
    for (int it = 0; it < 250; it++) begin
      int op;
      op = int'($urandom % 4);
      if (op == 0) wr(int'($urandom % 4), ($urandom % 2) ? ($urandom % 4) : $urandom);
      else if (op == 1) do_tick(4'($urandom), int'($urandom % 6) - 2, $urandom % 3, "R5 random");
      else if (op == 2) do_tick(4'hF, -1, 0, "R7 random");
      else rd_chk(int'($urandom % 4), "R5 random read");
    end
    rd_all("R6 final");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule